// File: doc/BRIEF.md
# AEGIS-128 State Update Unit

This unit advances the 640-bit internal state of the AEGIS-128 authenticated cipher by one step. The state is held as five 128-bit words. One 128-bit message word is absorbed per step. Each word is passed through a keyless AES round, meaning an AES round with an all-zero round key. The result is XORed into the next word around a ring of five, and the message word is folded into word 0 alone. All five rounds read the state as it was before the step.

The block serves a sequencer that loads keys, streams data and produces tags. That sequencer presents a state, a message word and a valid strobe. It receives the next state and a matching strobe. A parameter chooses between a registered variant and a purely combinational variant. The registered variant is the default and has one cycle of latency. In it the output register keeps its contents while no update is requested. The S-box, the byte rotation and the column mixing are all computed inside the block.

Top module: `aegis_state_update`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `state_out` is all zeros.
- R2: In registered mode, `out_valid` equals the value `in_valid` had on the previous rising clock edge.
- R3: Next word 0 (`state_out[127:0]`) equals S0 XOR M XOR round(S4). Word i occupies bits [128*i+127 : 128*i] of a state port.
- R4: For i = 1..4, next word i equals Si XOR round(S(i-1)). All five rounds use the state before the update.
- R5: The round is a byte rotation, then the AES forward S-box, then AES MixColumns, with no key addition. Within a word, byte k is bits [8k+7:8k]. The rotated byte k takes input byte (5*k mod 16). A column c holds bytes 4c..4c+3. An all-zero state with an all-zero message therefore yields 0x63 in every byte of all five words.
- R6: The message word affects only word 0. Two updates of one state with messages M1 and M2 give identical words 1..4, and their word-0 values differ by M1 XOR M2.
- R7: In registered mode, `state_out` keeps its value on any cycle where `in_valid` is 0, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request one update of `state_in` with `msg_in` |
| state_in | input | 640 | Current state, word i at bits [128*i +: 128] |
| msg_in | input | 128 | Message word absorbed into word 0 |
| out_valid | output | 1 | Next state valid |
| state_out | output | 640 | Next state, same word layout as `state_in` |

## Verification
The update is first tried with an all-zero state and message. This isolates the zero-key round constant 0x63 and would expose any stray key or a missing MixColumns step. A single set bit walked through each state word in turn shows which output words it reaches, which separates a correct ring from one that is wrongly rotated or mirrored. Pseudo-random states show byte-order and permutation errors that symmetric patterns hide. Repeating one state with two different messages shows that the message reaches word 0 alone. Idle cycles with changing data inputs show that the output register holds its value.

// File: rtl/aegis_pkg.sv
package aegis_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_BYTES = 16;
    localparam int WORD_W    = BYTE_W * WORD_BYTES;
    localparam int NUM_WORDS = 5;
    localparam int STATE_W   = WORD_W * NUM_WORDS;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [NUM_WORDS-1:0] state_t;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_dbl(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t t   = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) acc = acc ^ t;
            t = gf_dbl(t);
        end
        return acc;
    endfunction

    // a^254 by square-and-multiply (zero maps to zero)
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r = 8'h01;
        for (int k = 7; k >= 0; k--) begin
            r = gf_mul(r, r);
            if (k != 0) r = gf_mul(r, a);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t aes_sbox(input byte_t a);
        byte_t b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction
endpackage

// File: rtl/aegis_sbox.sv
module aegis_sbox
    import aegis_pkg::*;
(
    input  byte_t in_byte,
    output byte_t out_byte
);
    assign out_byte = aes_sbox(in_byte);
endmodule

// File: rtl/aegis_aes_round.sv
module aegis_aes_round
    import aegis_pkg::*;
(
    input  word_t din,
    output word_t dout
);
    localparam int NCOL = WORD_BYTES / 4;

    byte_t rot_b [WORD_BYTES];
    byte_t sub_b [WORD_BYTES];

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
        localparam int SRC = (5 * k) % WORD_BYTES;
        assign rot_b[k] = din[BYTE_W*SRC +: BYTE_W];
        aegis_sbox u_sbox (.in_byte(rot_b[k]), .out_byte(sub_b[k]));
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        byte_t a0, a1, a2, a3;
        byte_t d0, d1, d2, d3;
        assign a0 = sub_b[4*c];
        assign a1 = sub_b[4*c+1];
        assign a2 = sub_b[4*c+2];
        assign a3 = sub_b[4*c+3];
        assign d0 = gf_dbl(a0);
        assign d1 = gf_dbl(a1);
        assign d2 = gf_dbl(a2);
        assign d3 = gf_dbl(a3);
        assign dout[BYTE_W*(4*c)   +: BYTE_W] = d0 ^ d1 ^ a1 ^ a2 ^ a3;
        assign dout[BYTE_W*(4*c+1) +: BYTE_W] = a0 ^ d1 ^ d2 ^ a2 ^ a3;
        assign dout[BYTE_W*(4*c+2) +: BYTE_W] = a0 ^ a1 ^ d2 ^ d3 ^ a3;
        assign dout[BYTE_W*(4*c+3) +: BYTE_W] = d0 ^ a0 ^ a1 ^ a2 ^ d3;
    end
endmodule

// File: rtl/aegis_state_update.sv
module aegis_state_update
    import aegis_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [STATE_W-1:0]  state_in,
    input  logic [WORD_W-1:0]   msg_in,
    output logic                out_valid,
    output logic [STATE_W-1:0]  state_out
);
    state_t cur;
    state_t rnd;
    state_t nxt;

    assign cur = state_t'(state_in);

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam int PREV = (i + NUM_WORDS - 1) % NUM_WORDS;
        aegis_aes_round u_round (.din(cur[i]), .dout(rnd[i]));
        if (i == 0) begin : g_inject
            assign nxt[i] = cur[i] ^ msg_in ^ rnd[PREV];
        end else begin : g_chain
            assign nxt[i] = cur[i] ^ rnd[PREV];
        end
    end

    if (REG_OUT) begin : g_reg
        logic   v_q;
        state_t s_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                s_q <= '0;
            end else begin
                v_q <= in_valid;
                if (in_valid) s_q <= nxt;
            end
        end

        assign out_valid = v_q;
        assign state_out = STATE_W'(s_q);

        // R2
        valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        // R2
        no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        // R7
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(state_out));
        // R5
        zero_key_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && state_in == '0 && msg_in == '0) |=>
            (state_out == {(STATE_W/BYTE_W){8'h63}}));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign state_out = STATE_W'(nxt);
    end
endmodule

// File: tb/aegis_state_update_tb.sv
module aegis_state_update_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [639:0] state_in = '0;
    logic [127:0] msg_in = '0;
    logic         out_valid;
    logic [639:0] state_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] sbox_tbl [256];

    logic         exp_v;
    logic [639:0] exp_s;
    logic         live_check = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aegis_state_update u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .state_in(state_in), .msg_in(msg_in),
        .out_valid(out_valid), .state_out(state_out)
    );

    // build the S-box by walking generator 3 and its inverse together
    function automatic void build_sbox();
        logic [7:0] p = 8'h01;
        logic [7:0] q = 8'h01;
        logic [7:0] x;
        do begin
            p = p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1B : 8'h00);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sbox_tbl[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sbox_tbl[0] = 8'h63;
    endfunction

    function automatic logic [7:0] xt(input logic [7:0] a);
        return (a << 1) ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [127:0] ref_round(input logic [127:0] w);
        logic [7:0] b [16];
        logic [7:0] s [16];
        logic [127:0] r;
        for (int k = 0; k < 16; k++) b[k] = w[8*k +: 8];
        for (int k = 0; k < 16; k++) s[k] = sbox_tbl[b[(k*5) % 16]];
        for (int c = 0; c < 4; c++) begin
            logic [7:0] t;
            t = s[4*c] ^ s[4*c+1] ^ s[4*c+2] ^ s[4*c+3];
            for (int j = 0; j < 4; j++)
                r[8*(4*c+j) +: 8] = s[4*c+j] ^ t ^ xt(s[4*c+j] ^ s[4*c+((j+1)%4)]);
        end
        return r;
    endfunction

    function automatic logic [639:0] ref_update(input logic [639:0] st, input logic [127:0] m);
        logic [639:0] n;
        for (int i = 0; i < 5; i++) begin
            int pv;
            pv = (i == 0) ? 4 : i - 1;
            n[128*i +: 128] = st[128*i +: 128] ^ ref_round(st[128*pv +: 128]) ^ (i == 0 ? m : 128'h0);
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [639:0] act, input logic [639:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        if (rst) begin
            exp_v <= 1'b0;
            exp_s <= '0;
        end else begin
            exp_v <= in_valid;
            if (in_valid) exp_s <= ref_update(state_in, msg_in);
        end
    end

    always @(negedge clk) begin
        if (live_check) begin
            check("R2 valid", {639'h0, out_valid}, {639'h0, exp_v});
            check("R3 word0", {512'h0, state_out[127:0]}, {512'h0, exp_s[127:0]});
            check(exp_v ? "R4 words1-4" : "R7 hold", {128'h0, state_out[639:128]}, {128'h0, exp_s[639:128]});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input logic v, input logic [639:0] s, input logic [127:0] m);
        @(posedge clk); #1;
        in_valid = v;
        state_in = s;
        msg_in   = m;
    endtask

    task automatic one_shot(input logic [639:0] s, input logic [127:0] m, output logic [639:0] res);
        step(1'b1, s, m);
        step(1'b0, s, m);
        @(negedge clk);
        res = state_out;
    endtask

    function automatic logic [639:0] rnd640();
        logic [639:0] r;
        for (int k = 0; k < 20; k++) r[32*k +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        logic [639:0] r1, r2, s;
        logic [127:0] m1, m2;
        build_sbox();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 reset valid", {639'h0, out_valid}, 640'h0);
        check("R1 reset state", state_out, 640'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {state_out[638:0], out_valid}, 640'h0);
        live_check = 1'b1;

        // R5 zero state and zero message give 0x63 everywhere
        one_shot(640'h0, 128'h0, r1);
        check("R5 zero-key round", r1, {80{8'h63}});

        // all-ones pattern
        one_shot({640{1'b1}}, {128{1'b1}}, r1);

        // R4 walking single bit through each word
        for (int w = 0; w < 5; w++) begin
            for (int b = 0; b < 128; b += 37) begin
                s = '0;
                s[128*w + b] = 1'b1;
                one_shot(s, 128'h0, r1);
                check("R4 walk", r1, ref_update(s, 128'h0));
            end
        end

        // R3 R4 back-to-back random updates
        for (int k = 0; k < 40; k++)
            step(1'b1, rnd640(), {$urandom, $urandom, $urandom, $urandom});
        // R7 idle cycles with moving data
        for (int k = 0; k < 10; k++)
            step(1'b0, rnd640(), {$urandom, $urandom, $urandom, $urandom});
        // mixed valid pattern
        for (int k = 0; k < 40; k++)
            step(k % 3 != 0, rnd640(), {$urandom, $urandom, $urandom, $urandom});
        step(1'b0, '0, '0);

        // R6 message reaches word 0 only
        s  = rnd640();
        m1 = {$urandom, $urandom, $urandom, $urandom};
        m2 = ~m1;
        one_shot(s, m1, r1);
        one_shot(s, m2, r2);
        check("R6 words1-4 unchanged", {128'h0, r1[639:128]}, {128'h0, r2[639:128]});
        check("R6 word0 delta", {512'h0, r1[127:0] ^ r2[127:0]}, {512'h0, m1 ^ m2});

        repeat (3) @(posedge clk);
        @(negedge clk);
        live_check = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule